// File: doc/BRIEF.md
# Rectangle Descriptor Lookup-Table Refill Engine

This block masters a memory read port to load page addresses into a two-dimensional page-translation lookup table. Software first builds a linked chain of rectangle descriptors in memory. It then writes the byte address of the first descriptor to the engine's descriptor register. The engine fetches each descriptor and, for each slot of the rectangle, fetches the page address for that slot from a packed array. It then drives one write to the table for that slot. The engine follows the next pointers until it reaches a zero pointer.

Each descriptor is five 32-bit words at a 16-byte-aligned byte address. Word 0 is the next-descriptor address, where zero ends the chain. Word 1 holds x0 in bits [15:0] and y0 in bits [31:16]. Word 2 holds x1 and y1 in the same positions. Word 3 is the control word, with the start flag in bit 0 and the table id in bits [5:4]. Word 4 is the 16-byte-aligned byte address of the page array. Slot i of a w×h rectangle takes the word at array address + 4·i, and slots are taken row by row.

Software reaches the engine through a small register port. Offset 0 holds the descriptor pointer. Offset 1 is status: bit 0 ready, bit 1 valid, bit 2 done, bit 3 error. Offset 2 is the interrupt status register: this engine's 8-bit field is bits [7:0], with bit 0 for a completed chain and bit 1 for a fault. Offset 3 is hardware info, with the engine count in bits [28:24] and the table count in bits [20:16].

Top module: `lut_refill_engine`

## Requirements
- R1: After reset, status reads 0x1 (ready only), interrupt status reads 0 and `irq` is low.
- R2: Hardware info reads NUM_ENGINES in bits [28:24], NUM_TABLES in bits [20:16] and zero elsewhere (0x0102_0000 by default).
- R3: A nonzero, 16-byte-aligned write to offset 0 while ready starts a walk. For each slot, in row-major order, the engine drives one table write with `tbl_x`/`tbl_y` equal to the slot coordinates, `tbl_id` equal to control bits [5:4], and `tbl_data` equal to the array word for that slot. Each memory request lasts one cycle.
- R4: The engine follows nonzero next pointers and stops after the descriptor whose next pointer is zero. A descriptor whose start bit (control bit 0) is clear causes no table writes, but the walk continues past it.
- R5: Bits [2:0] of status read 0 while a walk runs. A chain that completes sets ready, valid and done together (0x7).
- R6: Completion of a chain sets interrupt status bit 0, and `irq` is high while any interrupt status bit is set.
- R7: Writing to offset 2 clears each interrupt status bit written as one and leaves the bits written as zero unchanged.
- R8: Writing zero to offset 0 aborts any walk within one cycle, with no further table writes. It returns status to 0x1 and raises no interrupt bit.
- R9: A nonzero write to offset 0 while the engine is busy is ignored, and the running chain completes unchanged. It sets sticky status bit 3 and interrupt bit 1. Bit 3 stays set until a zero write to offset 0.
- R10: A start, next or page-array address whose bits [3:0] are not zero, or a descriptor with x1<x0 or y1<y0, stops the walk. The engine returns to ready with status bit 3 set, valid and done clear, and interrupt bit 1 set.
- R11: Ready returns exactly Σ(11 + 3·Nᵢ) clock edges after the edge that registers the start write. Nᵢ is the slot count of descriptor i, and is 0 for a descriptor whose start bit is clear. This assumes memory answers each request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt, high while any status bit is set |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| tbl_we | output | 1 | Table write strobe |
| tbl_id | output | 2 | Target table |
| tbl_x | output | 8 | Table column |
| tbl_y | output | 7 | Table row |
| tbl_data | output | 32 | Page address written |

## Verification
A register write takes effect at the next edge, and status follows at once because it is read combinationally. Each descriptor word costs two edges: one for the request and one for the response. Each slot costs three edges, and leaving a descriptor costs one more. The bench therefore counts edges after the start edge until ready is seen, and compares the count with the R11 sum. It samples status, interrupt status and the table-write log only on falling edges, after the edge that should have produced them. A log of captured table writes is compared entry by entry with coordinates and data computed arithmetically. This is done for every rectangle from 1×1 to 4×3.

// File: rtl/lut_refill_pkg.sv
package lut_refill_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_DREQ, ST_DWAIT, ST_PREQ, ST_PWAIT, ST_WRITE, ST_NEXT
    } walk_st_e;

    localparam logic [2:0] LAST_WORD = 3'd4;   // descriptor is five words
    localparam logic [1:0] OFF_DESC  = 2'd0;
    localparam logic [1:0] OFF_STAT  = 2'd1;
    localparam logic [1:0] OFF_IRQ   = 2'd2;
    localparam logic [1:0] OFF_INFO  = 2'd3;
    localparam int IRQ_LAST  = 0;
    localparam int IRQ_FAULT = 1;
endpackage

// File: rtl/refill_walker.sv
module refill_walker
    import lut_refill_pkg::*;
#(
    parameter int X_W   = 8,
    parameter int Y_W   = 7,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic             cancel_wr,
    input  logic [31:0]      start_addr,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             tbl_we,
    output logic [TID_W-1:0] tbl_id,
    output logic [X_W-1:0]   tbl_x,
    output logic [Y_W-1:0]   tbl_y,
    output logic [31:0]      tbl_data,
    output logic             ready,
    output logic             valid,
    output logic             done,
    output logic             err,
    output logic             fin_ok,
    output logic             fin_err,
    output logic [31:0]      desc_ptr
);
    typedef struct packed {
        walk_st_e          st;
        logic [31:0]       desc;
        logic [2:0]        widx;
        logic [31:0]       next;
        logic [X_W-1:0]    x0, x1, x;
        logic [Y_W-1:0]    y0, y1, y;
        logic              go;
        logic [TID_W-1:0]  tid;
        logic [31:0]       data;
        logic [15:0]       slot;
        logic [31:0]       pg;
        logic              valid, done, err;
    } walk_t;

    walk_t q, d;

    always_comb begin
        d       = q;
        fin_ok  = 1'b0;
        fin_err = 1'b0;
        case (q.st)
            ST_DREQ:  d.st = ST_DWAIT;
            ST_DWAIT: if (mem_rvalid) begin
                case (q.widx)
                    3'd0: d.next = mem_rdata;
                    3'd1: begin d.x0 = mem_rdata[X_W-1:0]; d.y0 = mem_rdata[16 +: Y_W]; end
                    3'd2: begin d.x1 = mem_rdata[X_W-1:0]; d.y1 = mem_rdata[16 +: Y_W]; end
                    3'd3: begin d.go = mem_rdata[0]; d.tid = mem_rdata[4 +: TID_W]; end
                    default: d.data = mem_rdata;
                endcase
                if (q.widx == LAST_WORD) begin
                    if (mem_rdata[3:0] != 4'h0 || q.x1 < q.x0 || q.y1 < q.y0) begin
                        d.err = 1'b1; d.st = ST_IDLE; fin_err = 1'b1;
                    end else if (!q.go) begin
                        d.st = ST_NEXT;
                    end else begin
                        d.x = q.x0; d.y = q.y0; d.slot = '0; d.st = ST_PREQ;
                    end
                end else begin
                    d.widx = q.widx + 3'd1;
                    d.st   = ST_DREQ;
                end
            end
            ST_PREQ:  d.st = ST_PWAIT;
            ST_PWAIT: if (mem_rvalid) begin
                d.pg = mem_rdata;
                d.st = ST_WRITE;
            end
            ST_WRITE: begin
                d.slot = q.slot + 16'd1;
                d.st   = ST_PREQ;
                if (q.x == q.x1) begin
                    d.x = q.x0;
                    if (q.y == q.y1) d.st = ST_NEXT;
                    else             d.y = q.y + 1'b1;
                end else begin
                    d.x = q.x + 1'b1;
                end
            end
            ST_NEXT: begin
                if (q.next == 32'h0) begin
                    d.valid = 1'b1; d.done = 1'b1; d.st = ST_IDLE; fin_ok = 1'b1;
                end else if (q.next[3:0] != 4'h0) begin
                    d.err = 1'b1; d.st = ST_IDLE; fin_err = 1'b1;
                end else begin
                    d.desc = q.next; d.widx = '0; d.st = ST_DREQ;
                end
            end
            default: ;
        endcase
        if (cancel_wr) begin
            d.st = ST_IDLE; d.valid = 1'b0; d.done = 1'b0; d.err = 1'b0;
            d.desc = '0;
            fin_ok = 1'b0; fin_err = 1'b0;
        end else if (start_wr) begin
            if (q.st != ST_IDLE || start_addr[3:0] != 4'h0) begin
                d.err = 1'b1; fin_err = 1'b1;
            end else begin
                d.desc = start_addr; d.widx = '0; d.st = ST_DREQ;
                d.valid = 1'b0; d.done = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_req  = (q.st == ST_DREQ) || (q.st == ST_PREQ);
    assign mem_addr = (q.st == ST_DREQ) ? q.desc + {27'b0, q.widx, 2'b00}
                                        : q.data + {14'b0, q.slot, 2'b00};
    assign tbl_we   = (q.st == ST_WRITE);
    assign tbl_id   = q.tid;
    assign tbl_x    = q.x;
    assign tbl_y    = q.y;
    assign tbl_data = q.pg;
    assign ready    = (q.st == ST_IDLE);
    assign valid    = q.valid;
    assign done     = q.done;
    assign err      = q.err;
    assign desc_ptr = q.desc;

    // R8
    cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_wr |=> ready);
    // R9
    busy_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !ready) |=> err);
    // R5
    done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (ready && valid));
    // R3
    mem_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
endmodule

// File: rtl/refill_irq.sv
module refill_irq
    import lut_refill_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_last,
    input  logic               set_fault,
    input  logic               clr_wr,
    input  logic [FIELD_W-1:0] clr_mask,
    output logic [FIELD_W-1:0] stat,
    output logic               irq
);
    logic [FIELD_W-1:0] stat_d, stat_q, set_vec;

    always_comb begin
        set_vec            = '0;
        set_vec[IRQ_LAST]  = set_last;
        set_vec[IRQ_FAULT] = set_fault;
        stat_d = stat_q;
        if (clr_wr) stat_d = stat_d & ~clr_mask;
        stat_d = stat_d | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;
    assign irq  = |stat_q;

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[IRQ_LAST] && !set_last) |=> !stat_q[IRQ_LAST]);
    // R6
    last_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_last |=> (stat_q[IRQ_LAST] && irq));
endmodule

// File: rtl/lut_refill_engine.sv
module lut_refill_engine
    import lut_refill_pkg::*;
#(
    parameter int X_W         = 8,
    parameter int Y_W         = 7,
    parameter int TID_W       = 2,
    parameter int NUM_ENGINES = 1,
    parameter int NUM_TABLES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             tbl_we,
    output logic [TID_W-1:0] tbl_id,
    output logic [X_W-1:0]   tbl_x,
    output logic [Y_W-1:0]   tbl_y,
    output logic [31:0]      tbl_data
);
    localparam int FIELD_W = 8;
    localparam logic [4:0] ENG_CNT = 5'(NUM_ENGINES);
    localparam logic [4:0] TBL_CNT = 5'(NUM_TABLES);
    localparam logic [31:0] HWINFO = {3'b0, ENG_CNT, 3'b0, TBL_CNT, 16'h0};

    logic desc_wr, start_wr, cancel_wr;
    logic ready, valid, done, err, fin_ok, fin_err;
    logic [31:0] desc_ptr;
    logic [FIELD_W-1:0] irq_stat;

    assign desc_wr   = reg_wr && (reg_addr == OFF_DESC);
    assign start_wr  = desc_wr && (reg_wdata != 32'h0);
    assign cancel_wr = desc_wr && (reg_wdata == 32'h0);

    refill_walker #(.X_W(X_W), .Y_W(Y_W), .TID_W(TID_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .start_wr(start_wr), .cancel_wr(cancel_wr), .start_addr(reg_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tbl_we(tbl_we), .tbl_id(tbl_id), .tbl_x(tbl_x), .tbl_y(tbl_y),
        .tbl_data(tbl_data),
        .ready(ready), .valid(valid), .done(done), .err(err),
        .fin_ok(fin_ok), .fin_err(fin_err), .desc_ptr(desc_ptr)
    );

    refill_irq #(.FIELD_W(FIELD_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_last(fin_ok), .set_fault(fin_err),
        .clr_wr(reg_wr && (reg_addr == OFF_IRQ)),
        .clr_mask(reg_wdata[FIELD_W-1:0]),
        .stat(irq_stat), .irq(irq)
    );

    always_comb begin
        case (reg_addr)
            OFF_DESC: reg_rdata = desc_ptr;
            OFF_STAT: reg_rdata = {28'h0, err, done, valid, ready};
            OFF_IRQ:  reg_rdata = {{(32-FIELD_W){1'b0}}, irq_stat};
            default:  reg_rdata = HWINFO;
        endcase
    end
endmodule

// File: tb/tb_lut_refill_engine.sv
module tb_lut_refill_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic irq, mem_req, mem_rvalid = 1'b0, tbl_we;
    logic [31:0] mem_addr, mem_rdata = 32'h0, tbl_data;
    logic [1:0] tbl_id;
    logic [7:0] tbl_x;
    logic [6:0] tbl_y;

    int checks = 0;
    int fails = 0;
    logic [31:0] mem [0:1023];
    int nlog = 0;
    int lx [0:63];
    int ly [0:63];
    int lid [0:63];
    logic [31:0] ldat [0:63];

    always #4 clk = ~clk;

    lut_refill_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .tbl_we(tbl_we), .tbl_id(tbl_id),
        .tbl_x(tbl_x), .tbl_y(tbl_y), .tbl_data(tbl_data)
    );

    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem[mem_addr[11:2]];
    end

    always @(negedge clk) begin
        if (tbl_we && nlog < 64) begin
            lx[nlog] = int'(tbl_x); ly[nlog] = int'(tbl_y);
            lid[nlog] = int'(tbl_id); ldat[nlog] = tbl_data;
            nlog = nlog + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic put_desc(input int base, input logic [31:0] nxt, input int x0, input int y0,
                            input int x1, input int y1, input bit go, input int tid,
                            input logic [31:0] dat);
        mem[base/4]   = nxt;
        mem[base/4+1] = {16'(y0), 16'(x0)};
        mem[base/4+2] = {16'(y1), 16'(x1)};
        mem[base/4+3] = {26'h0, 2'(tid), 3'b0, go};
        mem[base/4+4] = dat;
    endtask

    // starts at the falling edge after the start edge; counts edges until ready
    task automatic wait_ready(output int n);
        logic [31:0] s;
        n = 0;
        rd(2'd1, s);
        while (s[0] == 1'b0 && n < 3000) begin
            @(negedge clk);
            n++;
            rd(2'd1, s);
        end
    endtask

    task automatic clean();
        wr(2'd0, 32'h0);
        wr(2'd2, 32'hFF);
        repeat (3) @(negedge clk);
        nlog = 0;
    endtask

    initial begin
        #1200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, v); chk("R1 status", v, 32'h1);
        rd(2'd2, v); chk("R1 irq status", v, 32'h0);
        chk("R1 irq pin", {31'h0, irq}, 32'h0);
        // R2 hardware info
        rd(2'd3, v); chk("R2 hwinfo", v, 32'h0102_0000);

        // R3 R5 R6 R11 single 3x2 rectangle
        put_desc(32'h100, 32'h0, 4, 9, 6, 10, 1'b1, 1, 32'h200);
        for (int i = 0; i < 6; i++) mem[32'h200/4 + i] = 32'h8000_1000 + 32'(i) * 32'h1000;
        wr(2'd0, 32'h100);
        rd(2'd1, v); chk("R5 busy status", v & 32'h7, 32'h0);
        wait_ready(n);
        chk("R11 latency 3x2", 32'(n), 32'(11 + 18));
        chk("R3 write count", 32'(nlog), 32'd6);
        for (int i = 0; i < 6; i++) begin
            chk("R3 x", 32'(lx[i]), 32'(4 + i % 3));
            chk("R3 y", 32'(ly[i]), 32'(9 + i / 3));
            chk("R3 id", 32'(lid[i]), 32'd1);
            chk("R3 data", ldat[i], 32'h8000_1000 + 32'(i) * 32'h1000);
        end
        rd(2'd1, v); chk("R5 done status", v, 32'h7);
        @(negedge clk);
        rd(2'd2, v); chk("R6 irq last bit", v, 32'h1);
        chk("R6 irq pin", {31'h0, irq}, 32'h1);

        // R7 write-one-to-clear
        wr(2'd2, 32'h0);
        rd(2'd2, v); chk("R7 zero write keeps", v, 32'h1);
        wr(2'd2, 32'h1);
        rd(2'd2, v); chk("R7 one write clears", v, 32'h0);
        chk("R7 irq pin low", {31'h0, irq}, 32'h0);
        clean();

        // R4 chain with a skipped descriptor
        put_desc(32'h100, 32'h140, 0, 0, 1, 1, 1'b1, 1, 32'h200);
        put_desc(32'h140, 32'h180, 7, 7, 9, 9, 1'b0, 0, 32'h300);
        put_desc(32'h180, 32'h0, 20, 30, 20, 30, 1'b1, 0, 32'h210);
        for (int i = 0; i < 4; i++) mem[32'h200/4 + i] = 32'h00A0_0000 + 32'(i);
        mem[32'h210/4] = 32'hDEAD_B000;
        wr(2'd0, 32'h100);
        wait_ready(n);
        chk("R11 chain latency", 32'(n), 32'(23 + 11 + 14));
        chk("R4 chain writes", 32'(nlog), 32'd5);
        chk("R4 second id", 32'(lid[4]), 32'd0);
        chk("R4 last x", 32'(lx[4]), 32'd20);
        chk("R4 last y", 32'(ly[4]), 32'd30);
        chk("R4 last data", ldat[4], 32'hDEAD_B000);
        chk("R4 first block data", ldat[3], 32'h00A0_0003);
        rd(2'd1, v); chk("R5 chain status", v, 32'h7);
        clean();

        // R9 busy start ignored
        put_desc(32'h100, 32'h0, 4, 9, 6, 10, 1'b1, 2, 32'h200);
        put_desc(32'h300, 32'h0, 0, 0, 0, 0, 1'b1, 0, 32'h240);
        wr(2'd0, 32'h100);
        wr(2'd0, 32'h300);
        rd(2'd1, v); chk("R9 error while busy", v & 32'h9, 32'h8);
        wait_ready(n);
        chk("R9 count unchanged", 32'(nlog), 32'd6);
        chk("R9 id kept", 32'(lid[0]), 32'd2);
        rd(2'd1, v); chk("R9 sticky error", v, 32'hF);
        @(negedge clk);
        rd(2'd2, v); chk("R9 irq bits", v, 32'h3);
        rd(2'd0, v); chk("R9 pointer kept", v, 32'h100);
        clean();
        rd(2'd1, v); chk("R9 cleared by zero write", v, 32'h1);

        // R8 cancel mid-walk
        wr(2'd0, 32'h100);
        n = 0;
        while (nlog < 2 && n < 500) begin @(negedge clk); n++; end
        wr(2'd0, 32'h0);
        rd(2'd1, v); chk("R8 ready after cancel", v, 32'h1);
        repeat (30) @(negedge clk);
        chk("R8 no more writes", 32'(nlog), 32'd2);
        rd(2'd2, v); chk("R8 no irq", v, 32'h0);
        clean();

        // R10 misaligned start
        wr(2'd0, 32'h104);
        rd(2'd1, v); chk("R10 bad start", v, 32'h9);
        @(negedge clk);
        rd(2'd2, v); chk("R10 fault irq", v, 32'h2);
        chk("R10 no writes", 32'(nlog), 32'd0);
        clean();

        // R10 misaligned next pointer
        put_desc(32'h100, 32'h208, 3, 3, 3, 3, 1'b1, 0, 32'h200);
        wr(2'd0, 32'h100);
        wait_ready(n);
        chk("R10 writes before bad next", 32'(nlog), 32'd1);
        rd(2'd1, v); chk("R10 bad next status", v, 32'h9);
        clean();

        // R10 misaligned data pointer and inverted rectangle
        put_desc(32'h100, 32'h0, 3, 3, 3, 3, 1'b1, 0, 32'h204);
        wr(2'd0, 32'h100);
        wait_ready(n);
        rd(2'd1, v); chk("R10 bad data status", v, 32'h9);
        chk("R10 bad data no writes", 32'(nlog), 32'd0);
        clean();
        put_desc(32'h100, 32'h0, 5, 3, 4, 3, 1'b1, 0, 32'h200);
        wr(2'd0, 32'h100);
        wait_ready(n);
        rd(2'd1, v); chk("R10 inverted rect status", v, 32'h9);
        chk("R10 inverted rect no writes", 32'(nlog), 32'd0);
        clean();

        // R3 R11 sweep over every rectangle up to 4x3
        for (int w = 1; w <= 4; w++) begin
            for (int h = 1; h <= 3; h++) begin
                put_desc(32'h100, 32'h0, 5 + w, 3 + h, 4 + 2 * w, 2 + 2 * h, 1'b1,
                         (w + h) % 2, 32'h200);
                for (int i = 0; i < w * h; i++)
                    mem[32'h200/4 + i] = 32'h4000_0000 + 32'(w * 256 + h * 16 + i);
                wr(2'd0, 32'h100);
                wait_ready(n);
                chk("R11 sweep latency", 32'(n), 32'(11 + 3 * w * h));
                chk("R3 sweep count", 32'(nlog), 32'(w * h));
                for (int i = 0; i < w * h; i++) begin
                    chk("R3 sweep x", 32'(lx[i]), 32'(5 + w + i % w));
                    chk("R3 sweep y", 32'(ly[i]), 32'(3 + h + i / w));
                    chk("R3 sweep id", 32'(lid[i]), 32'((w + h) % 2));
                    chk("R3 sweep data", ldat[i], 32'h4000_0000 + 32'(w * 256 + h * 16 + i));
                end
                rd(2'd1, v); chk("R5 sweep status", v, 32'h7);
                clean();
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule